// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a small field-configurable logic device. Twelve dedicated inputs and ten feedback lines are each offered to a programmable AND plane in both true and inverted form. Each row of that plane forms one product term. A fixed OR plane then gathers the terms into ten sums. The number of terms behind each sum is not uniform: it rises from the edge outputs toward the middle ones. Every output also has one extra term that serves as its enable. Two global terms drive the preset and the asynchronous clear of the downstream registers.

The connection pattern lives in an on-block configuration register. A one-bit serial port with a shift enable loads that register. The array itself has no clock. Its outputs follow the inputs combinationally, using whatever pattern is currently stored. A surrounding macrocell layer turns the sums into registered or combinational pins, with the enables and global terms alongside.

Top module: `pla_sop_array`

## Requirements
- R1: Signal s (inputs 0..N_IN-1 first, then feedback lines) owns two AND-plane columns. Column 2s carries the true value and column 2s+1 the inverted value. A configuration bit of 1 connects that column to the row.
- R2: Rows are laid out as follows. Row 0 is the asynchronous-clear term. Then, for each output o in ascending order, comes one enable row followed by that output's sum rows. The final row is the preset term. Output o owns TERMS_BASE + TERMS_STEP*min(o, N_OUT-1-o) sum rows, which gives 8,10,12,14,16,16,14,12,10,8 by default.
- R3: A product term with no connected column evaluates to 1.
- R4: A product term connected to both columns of any one signal evaluates to 0.
- R5: In all other cases, a product term is the AND of its connected columns.
- R6: sum_o[o] is the OR of the sum rows of output o only. oe_o[o] equals that output's enable row.
- R7: areset_o equals row 0, and preset_o equals the last row. Both are shared by all outputs.
- R8: While cfg_en is high, each rising clock edge shifts in one cfg_data bit. After ROWS*COLS shifts, the k-th bit shifted (counting from 0) sets row k/COLS, column k%COLS.
- R9: While cfg_en is low, the stored pattern does not change and cfg_data has no effect.
- R10: When rst_n is low, every configuration bit is cleared, so every output reads 1 (per R3). The release of rst_n is synchronized to clk.
- R11: Outputs respond to in_i and fb_i within the same clock cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the pattern |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_data | input | 1 | Serial configuration bit |
| in_i | input | N_IN | Dedicated inputs |
| fb_i | input | N_FB | Feedback lines |
| sum_o | output | N_OUT | Per-output sum of products |
| oe_o | output | N_OUT | Per-output enable term |
| preset_o | output | 1 | Global synchronous-preset term |
| areset_o | output | 1 | Global asynchronous-clear term |

## Verification
The bench builds the array with 3 inputs, 2 feedback lines and 4 outputs holding 2, 3, 3 and 2 sum terms. This gives 10 columns, 16 rows and a 160-bit chain. A full reload takes 160 cycles, and all 32 input combinations can be swept after every pattern. That makes it affordable to walk a single live term through every row, which proves the row layout and the OR grouping. The same sweep then runs several pseudo-random patterns, a pattern where every row contradicts itself, the held pattern with cfg_data toggling, and the cleared state after reset.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Sum-term count of output o: grows toward the centre of the output row.
  function automatic int pla_terms(input int o, input int n_out,
                                   input int base, input int step);
    int idx;
    idx = (o < n_out / 2) ? o : (n_out - 1 - o);
    return base + step * idx;
  endfunction

  // Row index of the enable term of output o (row 0 is the clear term).
  function automatic int pla_enable_row(input int o, input int n_out,
                                        input int base, input int step);
    int r;
    r = 1;
    for (int k = 0; k < o; k++) r += 1 + pla_terms(k, n_out, base, step);
    return r;
  endfunction

  // Total rows: clear + per-output (enable + sums) + preset.
  function automatic int pla_rows(input int n_out, input int base, input int step);
    return pla_enable_row(n_out, n_out, base, step) + 1;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int BITS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            shift_bit,
  output logic [BITS-1:0] pattern
);

  logic [BITS-1:0] pattern_q;
  logic [BITS-1:0] pattern_d;

  // New bit enters at the top and walks toward bit 0.
  always_comb begin
    pattern_d = pattern_q;
    if (shift_en) begin
      if (BITS > 1) pattern_d = {shift_bit, pattern_q[BITS-1:1]};
      else          pattern_d = shift_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pattern_q <= '0;
    else        pattern_q <= pattern_d;
  end

  assign pattern = pattern_q;

  // R8: an enabled edge lands the serial bit at the top of the chain
  a_r8_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (pattern[BITS-1] == $past(shift_bit)));

  // R9: with the enable low the pattern is frozen
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(pattern));

endmodule

// File: rtl/pla_and_row.sv
module pla_and_row #(
  parameter int COLS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [COLS-1:0] conn,
  input  logic [COLS-1:0] lits,
  output logic            term
);

  localparam int PAIRS = COLS / 2;

  // A column that is not connected contributes a 1 to the AND.
  always_comb begin
    term = 1'b1;
    for (int c = 0; c < COLS; c++) begin
      if (conn[c] && !lits[c]) term = 1'b0;
    end
  end

  logic [PAIRS-1:0] pair_hit;
  always_comb begin
    for (int p = 0; p < PAIRS; p++) pair_hit[p] = conn[2*p] & conn[2*p+1];
  end

  // R3: an empty row is high
  a_r3_open_term_high: assert property (@(posedge clk) disable iff (!rst_n)
    (conn == '0) |-> term);

  // R4: both polarities of one signal force the row low
  a_r4_both_polarity_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_hit != '0) |-> !term);

  // R5: a low connected column always forces the row low
  a_r5_low_literal_kills: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(conn & ~lits) > 0) |-> !term);

endmodule

// File: rtl/pla_or_group.sv
module pla_or_group #(
  parameter int N_TERMS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TERMS-1:0] terms,
  output logic               sum
);

  always_comb begin
    sum = 1'b0;
    for (int t = 0; t < N_TERMS; t++) sum = sum | terms[t];
  end

  // R6: a high sum always has at least one live term behind it
  a_r6_sum_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    sum |-> ($countones(terms) > 0));

  // R6: a sum with no live term is low
  a_r6_sum_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(terms) == 0) |-> !sum);

endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array
  import pla_pkg::*;
#(
  parameter int N_IN       = 12,
  parameter int N_FB       = 10,
  parameter int N_OUT      = 10,
  parameter int TERMS_BASE = 8,
  parameter int TERMS_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_data,
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_FB-1:0]  fb_i,
  output logic [N_OUT-1:0] sum_o,
  output logic [N_OUT-1:0] oe_o,
  output logic             preset_o,
  output logic             areset_o
);

  localparam int N_SIG = N_IN + N_FB;
  localparam int COLS  = 2 * N_SIG;
  localparam int ROWS  = pla_rows(N_OUT, TERMS_BASE, TERMS_STEP);
  localparam int BITS  = ROWS * COLS;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q;
  logic rst_meta_d, rst_sync_d;

  always_comb begin
    rst_meta_d = 1'b1;
    rst_sync_d = rst_meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= rst_meta_d;
      rst_sync_q <= rst_sync_d;
    end
  end

  logic rst_sync_n;
  assign rst_sync_n = rst_sync_q & rst_n;

  // Configuration storage.
  logic [BITS-1:0] cfg_bits;

  pla_cfg_chain #(.BITS(BITS)) u_chain (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift_en  (cfg_en),
    .shift_bit (cfg_data),
    .pattern   (cfg_bits)
  );

  // Literal columns: true at even, inverted at odd.
  logic [N_SIG-1:0] sig;
  logic [COLS-1:0]  lits;
  assign sig = {fb_i, in_i};

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lits[2*s]   = sig[s];
    assign lits[2*s+1] = ~sig[s];
  end

  // AND plane.
  logic [ROWS-1:0] terms;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    pla_and_row #(.COLS(COLS)) u_row (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .conn  (cfg_bits[r*COLS +: COLS]),
      .lits  (lits),
      .term  (terms[r])
    );
  end

  // Fixed OR plane, one group per output.
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    localparam int EN_ROW = pla_enable_row(o, N_OUT, TERMS_BASE, TERMS_STEP);
    localparam int CNT    = pla_terms(o, N_OUT, TERMS_BASE, TERMS_STEP);

    assign oe_o[o] = terms[EN_ROW];

    pla_or_group #(.N_TERMS(CNT)) u_or (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .terms (terms[EN_ROW+1 +: CNT]),
      .sum   (sum_o[o])
    );
  end

  assign areset_o = terms[0];
  assign preset_o = terms[ROWS-1];

  // R10: the first cycle out of reset starts from an empty pattern
  a_r10_cleared_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (cfg_bits == '0));

  // R10: an empty pattern drives every output high
  a_r10_empty_all_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_bits == '0) |-> (&{sum_o, oe_o, preset_o, areset_o}));

endmodule

// File: tb/pla_sop_array_test.sv
module pla_sop_array_test;

  localparam int NI = 3, NF = 2, NO = 4, BB = 2, BS = 1;
  localparam int NS = NI + NF;
  localparam int NC = 2 * NS;      // 10 columns
  localparam int NR = 16;          // 1 + (1+2)+(1+3)+(1+3)+(1+2) + 1
  localparam int NB = NR * NC;     // 160 bits
  localparam int OW = 2 + 2 * NO;  // {areset, preset, oe, sum}

  logic clk = 1'b0;
  logic rst_n, cfg_en, cfg_data;
  logic [NI-1:0] in_i;
  logic [NF-1:0] fb_i;
  logic [NO-1:0] sum_o, oe_o;
  logic preset_o, areset_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit m [NB];

  always #2 clk = ~clk;

  pla_sop_array #(.N_IN(NI), .N_FB(NF), .N_OUT(NO),
                  .TERMS_BASE(BB), .TERMS_STEP(BS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_data(cfg_data),
    .in_i(in_i), .fb_i(fb_i), .sum_o(sum_o), .oe_o(oe_o),
    .preset_o(preset_o), .areset_o(areset_o));

  function automatic int cnt_of(int o);
    return BB + BS * ((o < NO - 1 - o) ? o : NO - 1 - o);
  endfunction

  function automatic int en_row(int o);
    int r = 1;
    for (int k = 0; k < o; k++) r += 1 + cnt_of(k);
    return r;
  endfunction

  function automatic bit row_val(int r, int v);
    bit t = 1;
    for (int c = 0; c < NC; c++) begin
      if (m[r*NC + c]) begin
        bit s = v[c/2];
        if ((c % 2) == 1) s = ~s;
        t &= s;
      end
    end
    return t;
  endfunction

  function automatic logic [OW-1:0] model(int v);
    logic [NO-1:0] s, e;
    for (int o = 0; o < NO; o++) begin
      e[o] = row_val(en_row(o), v);
      s[o] = 0;
      for (int t = 0; t < cnt_of(o); t++) s[o] |= row_val(en_row(o) + 1 + t, v);
    end
    return {row_val(0, v), row_val(NR - 1, v), e, s};
  endfunction

  task automatic check(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic load();
    for (int k = 0; k < NB; k++) begin
      @(negedge clk);
      cfg_en = 1; cfg_data = m[k];
    end
    @(negedge clk);
    cfg_en = 0; cfg_data = 0;
  endtask

  task automatic sweep(string tag);
    for (int v = 0; v < (1 << NS); v++) begin
      @(negedge clk);
      in_i = v[NI-1:0];
      fb_i = v[NS-1:NI];
      #1;
      check(tag, {areset_o, preset_o, oe_o, sum_o}, model(v));
    end
  endtask

  initial begin
    rst_n = 0; cfg_en = 0; cfg_data = 0; in_i = 0; fb_i = 0;
    foreach (m[k]) m[k] = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R10 R3 reset state", {areset_o, preset_o, oe_o, sum_o}, '1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    sweep("R10 R3 R11 empty pattern");

    // Every row contradicts itself on one signal: all outputs low.
    foreach (m[k]) m[k] = 0;
    for (int r = 0; r < NR; r++) begin
      m[r*NC + 2*(r%NS)] = 1; m[r*NC + 2*(r%NS) + 1] = 1;
    end
    load();
    sweep("R4 contradicting rows");
    check("R4 all low", {areset_o, preset_o, oe_o, sum_o}, '0);

    // One live row at a time, every other row forced low.
    for (int live = 0; live < NR; live++) begin
      foreach (m[k]) m[k] = 0;
      for (int r = 0; r < NR; r++) begin
        if (r == live) m[r*NC + (r % NC)] = 1;
        else begin m[r*NC] = 1; m[r*NC + 1] = 1; end
      end
      load();
      sweep("R1 R2 R6 R7 R8 single live row");
    end

    // Pseudo-random patterns.
    for (int seed = 1; seed <= 8; seed++) begin
      int unsigned x = seed * 32'h9E3779B9;
      for (int k = 0; k < NB; k++) begin
        x = x * 1103515245 + 12345;
        m[k] = ((x >> 16) % 5) == 0;
      end
      load();
      sweep("R5 R6 R7 R8 random pattern");
    end

    // Held pattern: cfg_data toggles with the enable low.
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      cfg_en = 0; cfg_data = k[0];
    end
    sweep("R9 pattern held");

    // Reset clears a loaded pattern.
    @(negedge clk);
    rst_n = 0;
    #1;
    foreach (m[k]) m[k] = 0;
    check("R10 cleared by reset", {areset_o, preset_o, oe_o, sum_o}, '1);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    sweep("R10 empty after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule